// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block decides when an external DRAM controller must run a refresh cycle and supplies the row to refresh. A programmable down-counter sets the refresh interval. Each time it runs out, the scheduler asks for the system bus over a request/grant handshake. After the bus is granted, it emits a one-cycle start strobe and presents the row address. The external controller generates the DRAM timing and signals completion with a done pulse. The row counter then moves on to the next row.

Software configures the block through a small write port. Select 0 loads the interval reload value. Select 1 writes the control bits: bit 0 turns the scheduler on, and writing a 1 to bit 1 clears the sticky overrun flag. If an interval expires while a refresh is still in progress, that expiry is not turned into a second request. It is recorded in the overrun flag instead.

Top module: `dram_refresh_sched`

## Requirements
- R1: After a synchronous reset, bus_req, rfsh_start and overrun are 0, rfsh_row is 0, the scheduler is off and the reload value is 0.
- R2: With reload value N written at select 0 and bit 0 of select 1 then written as 1, bus_req first rises N+1 cycles after the clock edge that applies the enabling write. Expiries then repeat every N+1 cycles without any further write.
- R3: Once raised, bus_req stays at 1 while no grant arrives, as long as the scheduler stays on.
- R4: rfsh_start is a pulse exactly one cycle wide. It appears in the cycle after the edge at which bus_gnt is sampled high while the request is waiting.
- R5: rfsh_row stays constant from the request until the refresh is acknowledged. At the acknowledging edge it increases by exactly one.
- R6: rfsh_done is accepted in the strobe cycle or in any later cycle of a granted refresh. bus_req is 0 in the cycle after the accepting edge.
- R7: An interval expiry while a refresh is requested or granted produces no extra refresh and sets overrun. overrun stays set until a control write with bit 1 at 1.
- R8: Writing bit 0 of select 1 as 0 stops the timer. A request not yet granted is withdrawn, and bus_req is 0 two cycles after the applying edge. A refresh already granted still completes and advances the row.
- R9: The 13-bit row counter wraps from 8191 to 0.
- R10: rfsh_done while no refresh is granted leaves rfsh_row unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0: interval reload value, 1: control bits |
| cfg_wdata | input | 16 | Write data |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| rfsh_row | output | 13 | Row address to refresh |
| rfsh_start | output | 1 | One-cycle refresh start strobe |
| rfsh_done | input | 1 | Refresh complete acknowledge |
| overrun | output | 1 | Sticky flag: an interval expired during a refresh |

## Verification
The bench measures the distance from enable to request for several reload values, including the smallest ones. A design that reloads off by one would move the request by a cycle and fail there. It holds the grant back for different numbers of cycles and acknowledges in the strobe cycle itself. A design that drops the request early, stretches the strobe, or ignores a same-cycle acknowledge would be caught by these checks. It lets an expiry land during a slow grant to expect overrun and no second refresh. It turns the scheduler off both before and after a grant, so a design that abandons a granted refresh, or keeps a stale request alive, would fail. It runs more than 8192 back-to-back refreshes to see the row wrap. It pulses done while idle to catch a row counter that advances on an unsolicited acknowledge.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    typedef enum logic [1:0] {
        RS_IDLE     = 2'd0,
        RS_WAIT_GNT = 2'd1,
        RS_STROBE   = 2'd2,
        RS_HOLD     = 2'd3
    } rs_state_e;

    localparam logic SEL_INTERVAL = 1'b0;
    localparam logic SEL_CONTROL  = 1'b1;
    localparam int unsigned CTL_RUN_BIT = 0;
    localparam int unsigned CTL_CLR_BIT = 1;

    typedef struct packed {
        logic load_iv;
        logic load_run;
        logic run_val;
        logic clr_ovr;
    } cfg_cmd_t;

    function automatic logic holds_bus(rs_state_e s);
        return s != RS_IDLE;
    endfunction

    function automatic logic takes_ack(rs_state_e s);
        return (s == RS_STROBE) || (s == RS_HOLD);
    endfunction

    function automatic cfg_cmd_t decode_cmd(logic wr, logic sel, logic run_bit, logic clr_bit);
        cfg_cmd_t c;
        c.load_iv  = wr && (sel == SEL_INTERVAL);
        c.load_run = wr && (sel == SEL_CONTROL);
        c.run_val  = run_bit;
        c.clr_ovr  = wr && (sel == SEL_CONTROL) && clr_bit;
        return c;
    endfunction

endpackage

// File: rtl/rfsh_cfg_regs.sv
module rfsh_cfg_regs
    import rfsh_pkg::*;
#(
    parameter int unsigned TIMER_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_wr,
    input  logic               cfg_sel,
    input  logic [TIMER_W-1:0] cfg_wdata,
    output logic [TIMER_W-1:0] interval,
    output logic               run,
    output logic               clr_ovr
);
    cfg_cmd_t cmd;

    always_comb begin
        cmd = decode_cmd(cfg_wr, cfg_sel, cfg_wdata[CTL_RUN_BIT], cfg_wdata[CTL_CLR_BIT]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            interval <= '0;
            run      <= 1'b0;
        end else begin
            if (cmd.load_iv) interval <= cfg_wdata;
            if (cmd.load_run) run <= cmd.run_val;
        end
    end

    assign clr_ovr = cmd.clr_ovr;

    a_r1_cfg_reset: assert property (@(posedge clk) rst |=> (!run && interval == '0));
endmodule

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
    parameter int unsigned TIMER_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [TIMER_W-1:0] interval,
    output logic               due
);
    logic [TIMER_W-1:0] cnt_q;
    logic               at_zero;

    assign at_zero = (cnt_q == '0);
    assign due     = run && at_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= interval;
        end else if (at_zero) begin
            cnt_q <= interval;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    a_r2_reload_after_due: assert property (@(posedge clk) disable iff (rst)
        due |=> (cnt_q == $past(interval)));
    a_r8_no_due_when_off: assert property (@(posedge clk) disable iff (rst)
        (!run && !$past(run)) |-> !due);
endmodule

// File: rtl/rfsh_bus_arbiter.sv
module rfsh_bus_arbiter
    import rfsh_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic due,
    input  logic bus_gnt,
    input  logic rfsh_done,
    input  logic clr_ovr,
    output logic bus_req,
    output logic rfsh_start,
    output logic row_adv,
    output logic overrun
);
    rs_state_e state_q, state_d;
    logic      ack;
    logic      miss;

    assign ack  = takes_ack(state_q) && rfsh_done;
    assign miss = due && holds_bus(state_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE:     if (due) state_d = RS_WAIT_GNT;
            RS_WAIT_GNT: begin
                if (!run)         state_d = RS_IDLE;
                else if (bus_gnt) state_d = RS_STROBE;
            end
            RS_STROBE:   state_d = rfsh_done ? RS_IDLE : RS_HOLD;
            RS_HOLD:     if (rfsh_done) state_d = RS_IDLE;
            default:     state_d = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RS_IDLE;
            overrun <= 1'b0;
        end else begin
            state_q <= state_d;
            if (miss)         overrun <= 1'b1;
            else if (clr_ovr) overrun <= 1'b0;
        end
    end

    assign bus_req    = holds_bus(state_q);
    assign rfsh_start = (state_q == RS_STROBE);
    assign row_adv    = ack;

    a_r4_start_one_cycle: assert property (@(posedge clk) disable iff (rst)
        rfsh_start |=> !rfsh_start);
    a_r4_start_follows_gnt: assert property (@(posedge clk) disable iff (rst)
        rfsh_start |-> ($past(bus_gnt) && $past(bus_req)));
    a_r3_req_held: assert property (@(posedge clk) disable iff (rst)
        (state_q == RS_WAIT_GNT && run && !bus_gnt) |=> bus_req);
    a_r6_release_after_ack: assert property (@(posedge clk) disable iff (rst)
        (rfsh_done && (rfsh_start || state_q == RS_HOLD)) |=> !bus_req);
    a_r7_overrun_set: assert property (@(posedge clk) disable iff (rst)
        (due && bus_req) |=> overrun);
    a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        (overrun && !clr_ovr) |=> overrun);
    a_r8_off_no_req: assert property (@(posedge clk) disable iff (rst)
        (!run && !bus_req) |=> !bus_req);
endmodule

// File: rtl/rfsh_row_counter.sv
module rfsh_row_counter #(
    parameter int unsigned ROW_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [ROW_W-1:0] row
);
    localparam logic [ROW_W-1:0] ROW_LAST = {ROW_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            row <= '0;
        end else if (adv) begin
            row <= (row == ROW_LAST) ? '0 : row + 1'b1;
        end
    end

    a_r5_row_hold: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(row));
    a_r9_row_wrap: assert property (@(posedge clk) disable iff (rst)
        (adv && row == ROW_LAST) |=> (row == '0));
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
    parameter int unsigned ROW_W   = 13,
    parameter int unsigned TIMER_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_wr,
    input  logic               cfg_sel,
    input  logic [TIMER_W-1:0] cfg_wdata,
    output logic               bus_req,
    input  logic               bus_gnt,
    output logic [ROW_W-1:0]   rfsh_row,
    output logic               rfsh_start,
    input  logic               rfsh_done,
    output logic               overrun
);
    logic [TIMER_W-1:0] interval;
    logic               run;
    logic               clr_ovr;
    logic               due;
    logic               row_adv;

    rfsh_cfg_regs #(.TIMER_W(TIMER_W)) u_cfg (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .interval(interval), .run(run), .clr_ovr(clr_ovr)
    );

    rfsh_interval_timer #(.TIMER_W(TIMER_W)) u_timer (
        .clk(clk), .rst(rst), .run(run), .interval(interval), .due(due)
    );

    rfsh_bus_arbiter u_arb (
        .clk(clk), .rst(rst), .run(run), .due(due), .bus_gnt(bus_gnt),
        .rfsh_done(rfsh_done), .clr_ovr(clr_ovr), .bus_req(bus_req),
        .rfsh_start(rfsh_start), .row_adv(row_adv), .overrun(overrun)
    );

    rfsh_row_counter #(.ROW_W(ROW_W)) u_row (
        .clk(clk), .rst(rst), .adv(row_adv), .row(rfsh_row)
    );

    a_r1_outputs_after_reset: assert property (@(posedge clk)
        rst |=> (!bus_req && !rfsh_start && !overrun && rfsh_row == '0));
    a_r10_done_idle_no_step: assert property (@(posedge clk) disable iff (rst)
        (rfsh_done && !bus_req) |=> $stable(rfsh_row));
endmodule

// File: tb/test_dram_refresh_sched.sv
module test_dram_refresh_sched;
    localparam int ROW_W   = 13;
    localparam int TIMER_W = 16;
    localparam int NVEC    = 5;
    localparam int ROWS    = 1 << ROW_W;

    localparam int V_RELOAD [NVEC] = '{20, 7, 33, 12, 2};
    localparam int V_GNT    [NVEC] = '{0, 2, 5, 1, 6};
    localparam int V_DONE   [NVEC] = '{0, 1, 3, 0, 2};
    localparam int V_OVR    [NVEC] = '{0, 0, 0, 0, 1};

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               cfg_wr = 1'b0;
    logic               cfg_sel = 1'b0;
    logic [TIMER_W-1:0] cfg_wdata = '0;
    logic               bus_req;
    logic               bus_gnt = 1'b0;
    logic [ROW_W-1:0]   rfsh_row;
    logic               rfsh_start;
    logic               rfsh_done = 1'b0;
    logic               overrun;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dram_refresh_sched #(.ROW_W(ROW_W), .TIMER_W(TIMER_W)) i_dram_refresh_sched (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .rfsh_row(rfsh_row), .rfsh_start(rfsh_start),
        .rfsh_done(rfsh_done), .overrun(overrun)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic sel, input int data);
        cfg_wr    = 1'b1;
        cfg_sel   = sel;
        cfg_wdata = TIMER_W'(data);
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    task automatic wait_req(output int n);
        n = 0;
        while (!bus_req && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int exp_row;
        int n;
        int mism;
        int starts;
        int prev_row;
        bit seen_wrap;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!bus_req && !rfsh_start && !overrun, "R1 reset outputs",
            {bus_req, rfsh_start, overrun}, 0);
        chk(rfsh_row == 0, "R1 reset row", rfsh_row, 0);

        // R10: done while idle has no effect
        rfsh_done = 1'b1;
        repeat (3) @(negedge clk);
        rfsh_done = 1'b0;
        @(negedge clk);
        chk(rfsh_row == 0 && !bus_req, "R10 done while idle", rfsh_row, 0);

        // R8: timer stays stopped while off
        cfg_write(1'b0, 4);
        repeat (20) @(negedge clk);
        chk(!bus_req, "R8 no request while off", bus_req, 0);

        exp_row = 0;
        for (int v = 0; v < NVEC; v++) begin
            bit held;
            bit noextra;
            cfg_write(1'b0, V_RELOAD[v]);
            cfg_write(1'b1, 1);
            wait_req(n);
            chk(n == V_RELOAD[v] + 1, $sformatf("R2 first request delay vec%0d", v), n, V_RELOAD[v] + 1);
            chk(rfsh_row == exp_row, $sformatf("R5 row at request vec%0d", v), rfsh_row, exp_row);
            held = 1'b1;
            for (int g = 0; g < V_GNT[v]; g++) begin
                @(negedge clk);
                if (!bus_req || rfsh_start) held = 1'b0;
            end
            chk(held, $sformatf("R3 request held without grant vec%0d", v), held, 1);
            bus_gnt = 1'b1;
            @(negedge clk);
            bus_gnt = 1'b0;
            chk(rfsh_start == 1'b1, $sformatf("R4 start after grant vec%0d", v), rfsh_start, 1);
            noextra = 1'b1;
            for (int d = 0; d < V_DONE[v]; d++) begin
                @(negedge clk);
                if (rfsh_start || rfsh_row != exp_row[ROW_W-1:0] || !bus_req) noextra = 1'b0;
            end
            chk(noextra, $sformatf("R4 R5 single strobe and stable row vec%0d", v), noextra, 1);
            rfsh_done = 1'b1;
            @(negedge clk);
            rfsh_done = 1'b0;
            exp_row = (exp_row + 1) % ROWS;
            chk(rfsh_row == exp_row, $sformatf("R5 row advance vec%0d", v), rfsh_row, exp_row);
            chk(!bus_req || V_RELOAD[v] < 3, $sformatf("R6 request released vec%0d", v), bus_req, 0);
            chk(overrun == V_OVR[v][0], $sformatf("R7 overrun vec%0d", v), overrun, V_OVR[v]);
            cfg_write(1'b1, 0);
            repeat (4) @(negedge clk);
            if (V_OVR[v] != 0) begin
                chk(overrun == 1'b1, "R7 overrun sticky", overrun, 1);
                chk(rfsh_row == exp_row, "R7 no duplicate refresh", rfsh_row, exp_row);
            end
            cfg_write(1'b1, 2);
            @(negedge clk);
            chk(!overrun && !bus_req, $sformatf("R7 overrun cleared vec%0d", v), {overrun, bus_req}, 0);
        end

        // R2: automatic reload gives repeated expiries with period N+1
        cfg_write(1'b0, 5);
        cfg_write(1'b1, 1);
        wait_req(n);
        bus_gnt = 1'b1;
        @(negedge clk);
        bus_gnt = 1'b0;
        rfsh_done = 1'b1;
        @(negedge clk);
        rfsh_done = 1'b0;
        exp_row = (exp_row + 1) % ROWS;
        // request at t=6, strobe t=7, idle t=8; next expiry t=11, request t=12
        wait_req(n);
        chk(n == 4, "R2 period of repeated expiry", n, 4);
        // R8: withdraw an ungranted request
        cfg_write(1'b1, 0);
        @(negedge clk);
        chk(!bus_req, "R8 pending request withdrawn", bus_req, 0);
        bus_gnt = 1'b1;
        n = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (rfsh_start) n++;
        end
        bus_gnt = 1'b0;
        chk(n == 0 && rfsh_row == exp_row, "R8 no strobe after withdraw", n, 0);

        // R8: granted refresh completes after switch-off
        cfg_write(1'b0, 3);
        cfg_write(1'b1, 1);
        wait_req(n);
        bus_gnt = 1'b1;
        @(negedge clk);
        bus_gnt = 1'b0;
        cfg_write(1'b1, 0);
        repeat (3) @(negedge clk);
        chk(bus_req == 1'b1, "R8 granted refresh kept", bus_req, 1);
        rfsh_done = 1'b1;
        @(negedge clk);
        rfsh_done = 1'b0;
        exp_row = (exp_row + 1) % ROWS;
        chk(rfsh_row == exp_row && !bus_req, "R8 granted refresh completed", rfsh_row, exp_row);
        repeat (10) @(negedge clk);
        chk(!bus_req, "R8 no new request after switch-off", bus_req, 0);

        // R1: reset returns the row to zero
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(rfsh_row == 0 && !bus_req, "R1 reset clears row", rfsh_row, 0);

        // R9: back-to-back refreshes across the wrap
        cfg_write(1'b0, 0);
        cfg_write(1'b1, 1);
        bus_gnt   = 1'b1;
        rfsh_done = 1'b1;
        starts = 0;
        mism = 0;
        prev_row = -1;
        seen_wrap = 1'b0;
        while (starts < ROWS + 2) begin
            @(negedge clk);
            if (rfsh_start) begin
                if (rfsh_row != (starts % ROWS)) mism++;
                if (prev_row == ROWS - 1 && rfsh_row == 0) seen_wrap = 1'b1;
                prev_row = rfsh_row;
                starts++;
            end
        end
        bus_gnt   = 1'b0;
        rfsh_done = 1'b0;
        cfg_write(1'b1, 0);
        chk(mism == 0, "R5 row steps by one per refresh", mism, 0);
        chk(seen_wrap, "R9 row wraps 8191 to 0", seen_wrap, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule